// File: doc/BRIEF.md
# Sticky Error Status Register

This block holds an 8-bit status word that records bus errors and event notifications for a bus bridge. Each implemented flag latches on a one-cycle pulse from its source: the interrupt generator, the bus-initialisation driver, either of two performance monitors, or the bus error detector. A flag then stays set until software writes a one to that bit position at the register's offset. The contents survive a warm reset. Only the power-good reset clears them, so recovery code that runs after a forced restart can still read why the restart happened.

Bus errors are sorted into two flags. A one-bit "first error held" state tracks whether a separate first-error capture register is occupied. An error that arrives while that state is clear is a first error: it sets the first-error flag and marks the capture as occupied. An error that arrives while the capture is occupied sets the next-error flag instead. A software strobe empties the capture. A configuration input selects the secondary-side variant, in which the bus-initialisation flag does not exist.

Top module: `sticky_err_status`

## Requirements
- R1: While `pwrgood_n` is low at a rising clock edge, every flag and `first_held` become 0. After that edge, a read at offset 0x44 returns 0x00.
- R2: `warm_rst_n` has no effect. The flags and `first_held` keep their values while it is low and after it goes high again.
- R3: A write is a clock edge with `reg_wr`=1 and `reg_addr`=0x44. It clears each flag whose `reg_wdata` bit is 1 and leaves each flag whose `reg_wdata` bit is 0 unchanged. Writes at any other address change nothing.
- R4: Event pulses set their flags at the clock edge, and the new value reads back in the following cycle: `irq_evt` sets bit 7, `businit_evt` sets bit 6, `pmon1_evt` sets bit 1, `pmon0_evt` sets bit 0.
- R5: A cycle with any bit of `bus_err` high while `first_held`=0 sets bit 3 (first error) and sets `first_held`.
- R6: A cycle with any bit of `bus_err` high while `first_held`=1, and `first_clr` low, sets bit 5 (next error). Bit 3 is left unchanged.
- R7: `first_clr` clears `first_held`. The clear takes effect before routing, so a bus error in the same cycle is treated as a first error (bit 3, and `first_held` stays 1).
- R8: Bits 4 and 2 always read 0, and writes to them are ignored. A read at any address other than 0x44 returns 0x00.
- R9: With `secondary_side`=1, bit 6 reads 0 and `businit_evt` is ignored.
- R10: When an event pulse and a write-one-to-clear hit the same bit in the same cycle, the bit ends up set.
- R11: Several `bus_err` bits high in one cycle count as one error. With no first error held, this sets only bit 3 and `first_held`, and the next error after that sets bit 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| pwrgood_n | input | 1 | Power-good (cold) reset, synchronous, active low |
| warm_rst_n | input | 1 | Warm reset, active low; flags ignore it |
| secondary_side | input | 1 | 1 selects the variant without bit 6 |
| reg_addr | input | ADDR_W (8) | Register access address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data; 1 bits clear flags |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| irq_evt | input | 1 | Interrupt request raised (pulse) |
| businit_evt | input | 1 | Bus-initialisation output asserted (pulse) |
| pmon0_evt | input | 1 | Performance monitor 0 event (pulse) |
| pmon1_evt | input | 1 | Performance monitor 1 event (pulse) |
| bus_err | input | ERR_SRCS (2) | Bus error reports, one bit per detector (pulse) |
| first_clr | input | 1 | Software strobe that empties the first-error capture |
| first_held | output | 1 | A first error is currently held |

## Verification
A wrong `first_held` state does not show up in the cycle of its own update. It shows up at the next bus error, which lands in bit 5 instead of bit 3 or the other way round, and it is visible on `first_held` one cycle after the edge. A flag update that is lost or spurious reads back wrong at offset 0x44 in the cycle right after the edge that should have written it. The bench therefore compares `reg_rdata` and `first_held` against a reference model after every edge, using random errors, clear strobes, resets and addresses. It catches such a fault within one cycle of the faulty edge, or within one cycle of the next bus error when the fault is in `first_held`.

// File: rtl/errsts_pkg.sv
// Package: shared constants for the sticky error status register.
// Holds the bit positions of every flag and the masks of the
// implemented bits, so the submodules agree on one layout.
package errsts_pkg;

    localparam int STAT_W      = 8;

    localparam int BIT_IRQ     = 7;
    localparam int BIT_BUSINIT = 6;
    localparam int BIT_NEXT    = 5;
    localparam int BIT_FIRST   = 3;
    localparam int BIT_PMON1   = 1;
    localparam int BIT_PMON0   = 0;

    // Bits that have storage at all (4 and 2 are reserved).
    localparam logic [STAT_W-1:0] IMPL_MASK =
        (STAT_W'(1) << BIT_IRQ)   | (STAT_W'(1) << BIT_BUSINIT) |
        (STAT_W'(1) << BIT_NEXT)  | (STAT_W'(1) << BIT_FIRST)   |
        (STAT_W'(1) << BIT_PMON1) | (STAT_W'(1) << BIT_PMON0);

    // Readable mask for the chosen side variant.
    function automatic logic [STAT_W-1:0] side_mask(input logic secondary);
        side_mask = secondary ? (IMPL_MASK & ~(STAT_W'(1) << BIT_BUSINIT))
                              : IMPL_MASK;
    endfunction

endpackage

// File: rtl/errsts_first_track.sv
// Module: first-error occupancy tracker.
// Holds one bit saying whether the first-error capture is occupied
// and routes each bus error cycle to the first or the next flag.
// Assumes bus_err bits are one-cycle pulses. A same-cycle clear
// strobe is applied before routing. Only the power-good reset clears it.
module errsts_first_track #(
    parameter int ERR_SRCS = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ERR_SRCS-1:0] bus_err,
    input  logic                first_clr,
    output logic                first_set,
    output logic                next_set,
    output logic                held
);

    logic held_q;
    logic any_err;
    logic held_eff;

    // Purpose: collapse all error sources and apply the clear ahead of routing.
    always_comb begin
        any_err   = |bus_err;
        held_eff  = held_q & ~first_clr;
        first_set = any_err & ~held_eff;
        next_set  = any_err & held_eff;
    end

    // Purpose: occupancy state, cleared on power-good reset only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= 1'b0;
        end else begin
            held_q <= held_eff | any_err;
        end
    end

    assign held = held_q;

endmodule

// File: rtl/errsts_event_map.sv
// Module: event-to-bit mapper.
// Places each source pulse at its flag position and drops the
// bus-initialisation pulse on the secondary-side variant.
// Purely combinational. Reserved positions are driven to zero.
module errsts_event_map
    import errsts_pkg::*;
(
    input  logic              secondary,
    input  logic              irq_evt,
    input  logic              businit_evt,
    input  logic              first_set,
    input  logic              next_set,
    input  logic              pmon1_evt,
    input  logic              pmon0_evt,
    output logic [STAT_W-1:0] set_vec
);

    // Purpose: build the per-bit set request vector.
    always_comb begin
        set_vec              = '0;
        set_vec[BIT_IRQ]     = irq_evt;
        set_vec[BIT_BUSINIT] = businit_evt & ~secondary;
        set_vec[BIT_NEXT]    = next_set;
        set_vec[BIT_FIRST]   = first_set;
        set_vec[BIT_PMON1]   = pmon1_evt;
        set_vec[BIT_PMON0]   = pmon0_evt;
    end

endmodule

// File: rtl/errsts_flag_array.sv
// Module: array of write-one-to-clear sticky flags.
// One storage bit per implemented position, chosen by IMPL_MASK.
// Reserved positions have no storage and read as zero.
// A set request wins over a clear in the same cycle.
module errsts_flag_array
    import errsts_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] set_vec,
    input  logic [STAT_W-1:0] clr_vec,
    output logic [STAT_W-1:0] flags
);

    for (genvar i = 0; i < STAT_W; i++) begin : g_bit
        if (IMPL_MASK[i]) begin : g_impl
            logic q;
            // Purpose: sticky flag with set priority over clear.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q <= 1'b0;
                end else begin
                    q <= set_vec[i] | (q & ~clr_vec[i]);
                end
            end
            assign flags[i] = q;
        end else begin : g_resv
            assign flags[i] = 1'b0;
        end
    end

endmodule

// File: rtl/errsts_regport.sv
// Module: register access port.
// Decodes the register offset, turns write data into a clear vector,
// and returns masked flags on a read at the offset or zero at any other
// address. Combinational read, single-cycle write strobe.
module errsts_regport
    import errsts_pkg::*;
#(
    parameter int              ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] REG_OFFSET = ADDR_W'('h44)
) (
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [STAT_W-1:0] reg_wdata,
    input  logic              secondary,
    input  logic [STAT_W-1:0] flags,
    output logic [STAT_W-1:0] clr_vec,
    output logic [STAT_W-1:0] reg_rdata
);

    logic hit;

    // Purpose: address decode, clear vector and read mux.
    always_comb begin
        hit       = (reg_addr == REG_OFFSET);
        clr_vec   = (hit && reg_wr) ? (reg_wdata & IMPL_MASK) : '0;
        reg_rdata = hit ? (flags & side_mask(secondary)) : '0;
    end

endmodule

// File: rtl/sticky_err_status.sv
// Module: sticky error status register, top level.
// Latches event and bus error pulses into write-one-to-clear flags
// that survive the warm reset. Bus errors go to the first-error or
// next-error flag depending on the first-error occupancy state.
// Assumes all event inputs are synchronous one-cycle pulses.
module sticky_err_status
    import errsts_pkg::*;
#(
    parameter int                ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] REG_OFFSET = ADDR_W'('h44),
    parameter int                ERR_SRCS   = 2
) (
    input  logic                clk,
    input  logic                pwrgood_n,
    input  logic                warm_rst_n,
    input  logic                secondary_side,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic                reg_wr,
    input  logic [STAT_W-1:0]   reg_wdata,
    output logic [STAT_W-1:0]   reg_rdata,
    input  logic                irq_evt,
    input  logic                businit_evt,
    input  logic                pmon0_evt,
    input  logic                pmon1_evt,
    input  logic [ERR_SRCS-1:0] bus_err,
    input  logic                first_clr,
    output logic                first_held
);

    logic              first_set;
    logic              next_set;
    logic [STAT_W-1:0] set_vec;
    logic [STAT_W-1:0] clr_vec;
    logic [STAT_W-1:0] flags_q;

    // The warm reset is deliberately left unconnected: flags are sticky.

    errsts_first_track #(
        .ERR_SRCS (ERR_SRCS)
    ) u_track (
        .clk       (clk),
        .rst_n     (pwrgood_n),
        .bus_err   (bus_err),
        .first_clr (first_clr),
        .first_set (first_set),
        .next_set  (next_set),
        .held      (first_held)
    );

    errsts_event_map u_map (
        .secondary   (secondary_side),
        .irq_evt     (irq_evt),
        .businit_evt (businit_evt),
        .first_set   (first_set),
        .next_set    (next_set),
        .pmon1_evt   (pmon1_evt),
        .pmon0_evt   (pmon0_evt),
        .set_vec     (set_vec)
    );

    errsts_flag_array u_flags (
        .clk     (clk),
        .rst_n   (pwrgood_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .flags   (flags_q)
    );

    errsts_regport #(
        .ADDR_W     (ADDR_W),
        .REG_OFFSET (REG_OFFSET)
    ) u_port (
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .secondary (secondary_side),
        .flags     (flags_q),
        .clr_vec   (clr_vec),
        .reg_rdata (reg_rdata)
    );

endmodule

// File: rtl/errsts_checker.sv
// Module: property checker for sticky_err_status, attached by bind.
// Observes ports and the flag storage vector. It drives nothing.
module errsts_checker
    import errsts_pkg::*;
#(
    parameter int                ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] REG_OFFSET = ADDR_W'('h44),
    parameter int                ERR_SRCS   = 2
) (
    input logic                clk,
    input logic                pwrgood_n,
    input logic                secondary_side,
    input logic [ADDR_W-1:0]   reg_addr,
    input logic                reg_wr,
    input logic [STAT_W-1:0]   reg_wdata,
    input logic [STAT_W-1:0]   reg_rdata,
    input logic                irq_evt,
    input logic                businit_evt,
    input logic                pmon0_evt,
    input logic                pmon1_evt,
    input logic [ERR_SRCS-1:0] bus_err,
    input logic                first_clr,
    input logic                first_held,
    input logic [STAT_W-1:0]   flags
);

    logic quiet;
    logic wr_hit;
    assign quiet  = !irq_evt && !businit_evt && !pmon0_evt && !pmon1_evt && (bus_err == '0);
    assign wr_hit = reg_wr && (reg_addr == REG_OFFSET);

    p_cold_clear_r1: assert property (@(posedge clk)
        !pwrgood_n |=> (flags == '0) && !first_held);

    p_hold_r2: assert property (@(posedge clk) disable iff (!pwrgood_n)
        (quiet && !wr_hit && !first_clr) |=> $stable(flags) && $stable(first_held));

    p_w1c_r3: assert property (@(posedge clk) disable iff (!pwrgood_n)
        (quiet && wr_hit) |=> ((flags & $past(reg_wdata)) == '0));

    p_pmon_r4: assert property (@(posedge clk) disable iff (!pwrgood_n)
        (pmon0_evt && pmon1_evt) |=> flags[BIT_PMON0] && flags[BIT_PMON1]);

    p_first_r5: assert property (@(posedge clk) disable iff (!pwrgood_n)
        ((bus_err != '0) && !first_held) |=> flags[BIT_FIRST] && first_held);

    p_next_r6: assert property (@(posedge clk) disable iff (!pwrgood_n)
        ((bus_err != '0) && first_held && !first_clr) |=> flags[BIT_NEXT]);

    p_clr_first_r7: assert property (@(posedge clk) disable iff (!pwrgood_n)
        (first_clr && (bus_err == '0)) |=> !first_held);

    p_reserved_r8: assert property (@(posedge clk) disable iff (!pwrgood_n)
        !reg_rdata[4] && !reg_rdata[2]);

    p_side_r9: assert property (@(posedge clk) disable iff (!pwrgood_n)
        secondary_side |-> !reg_rdata[BIT_BUSINIT]);

    p_set_wins_r10: assert property (@(posedge clk) disable iff (!pwrgood_n)
        irq_evt |=> flags[BIT_IRQ]);

endmodule

bind sticky_err_status errsts_checker #(
    .ADDR_W     (ADDR_W),
    .REG_OFFSET (REG_OFFSET),
    .ERR_SRCS   (ERR_SRCS)
) u_chk (
    .clk            (clk),
    .pwrgood_n      (pwrgood_n),
    .secondary_side (secondary_side),
    .reg_addr       (reg_addr),
    .reg_wr         (reg_wr),
    .reg_wdata      (reg_wdata),
    .reg_rdata      (reg_rdata),
    .irq_evt        (irq_evt),
    .businit_evt    (businit_evt),
    .pmon0_evt      (pmon0_evt),
    .pmon1_evt      (pmon1_evt),
    .bus_err        (bus_err),
    .first_clr      (first_clr),
    .first_held     (first_held),
    .flags          (flags_q)
);

// File: tb/sticky_err_status_test.sv
// Bench for sticky_err_status: directed corner cases, then seeded random
// traffic, all compared against a reference model kept in the bench.
module sticky_err_status_test;

    localparam int ADDR_W = 8;
    localparam logic [7:0] OFS = 8'h44;

    logic       clk = 1'b0;
    logic       pwrgood_n, warm_rst_n, secondary_side;
    logic [7:0] reg_addr, reg_wdata, reg_rdata;
    logic       reg_wr, irq_evt, businit_evt, pmon0_evt, pmon1_evt, first_clr, first_held;
    logic [1:0] bus_err;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // Reference state.
    logic [7:0] m_flags = 8'h00;
    logic       m_held  = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    sticky_err_status #(.ADDR_W(ADDR_W), .REG_OFFSET(OFS), .ERR_SRCS(2)) uut (
        .clk(clk), .pwrgood_n(pwrgood_n), .warm_rst_n(warm_rst_n),
        .secondary_side(secondary_side), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_evt(irq_evt),
        .businit_evt(businit_evt), .pmon0_evt(pmon0_evt), .pmon1_evt(pmon1_evt),
        .bus_err(bus_err), .first_clr(first_clr), .first_held(first_held)
    );

    function automatic logic [7:0] read_mask(input logic sec);
        return sec ? 8'hAB : 8'hEB;
    endfunction

    function automatic logic [7:0] exp_read(input logic [7:0] a, input logic sec);
        return (a == OFS) ? (m_flags & read_mask(sec)) : 8'h00;
    endfunction

    // Reference update for one clock edge.
    task automatic model_edge();
        logic eff;
        logic err;
        logic [7:0] setv;
        logic [7:0] clrv;
        if (!pwrgood_n) begin
            m_flags = 8'h00;
            m_held  = 1'b0;
        end else begin
            err  = |bus_err;
            eff  = m_held & ~first_clr;
            setv = {irq_evt, businit_evt & ~secondary_side, err & eff, 1'b0,
                    err & ~eff, 1'b0, pmon1_evt, pmon0_evt};
            clrv = (reg_wr && reg_addr == OFS) ? reg_wdata : 8'h00;
            m_flags = ((m_flags & ~clrv) | setv) & 8'hEB;
            m_held  = eff | err;
        end
    endtask

    task automatic check(input string tag);
        logic [7:0] e;
        e = exp_read(reg_addr, secondary_side);
        n_checks++;
        if (reg_rdata !== e) begin
            n_fail++;
            $display("FAIL %s rdata actual=%h expected=%h", tag, reg_rdata, e);
        end
        n_checks++;
        if (first_held !== m_held) begin
            n_fail++;
            $display("FAIL %s first_held actual=%b expected=%b", tag, first_held, m_held);
        end
    endtask

    task automatic idle();
        reg_wr = 0; reg_wdata = 0; irq_evt = 0; businit_evt = 0;
        pmon0_evt = 0; pmon1_evt = 0; bus_err = 0; first_clr = 0;
    endtask

    // One cycle: inputs already set at negedge; edge; check after it.
    task automatic cycle(input string tag);
        @(posedge clk);
        model_edge();
        #1;
        check(tag);
        @(negedge clk);
        idle();
        reg_addr = OFS;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : stim
        int seed;
        seed = 32'h5EED;
        void'($urandom(seed));
        idle();
        pwrgood_n = 0; warm_rst_n = 1; secondary_side = 0; reg_addr = OFS;
        @(negedge clk);
        cycle("R1 reset state");
        pwrgood_n = 1;

        // R4: each event source sets its own bit.
        irq_evt = 1; businit_evt = 1; pmon0_evt = 1; pmon1_evt = 1; cycle("R4 events");
        // R5 then R6, two sources together for R11.
        bus_err = 2'b11; cycle("R11 dual error first");
        bus_err = 2'b01; cycle("R6 next error");
        // R2: warm reset asserted and released.
        warm_rst_n = 0; cycle("R2 warm low");
        warm_rst_n = 0; cycle("R2 warm held");
        warm_rst_n = 1; cycle("R2 warm released");
        // R3: write zeros changes nothing; other address ignored.
        reg_wr = 1; reg_wdata = 8'h00; cycle("R3 write zero");
        reg_wr = 1; reg_addr = 8'h45; reg_wdata = 8'hFF; cycle("R8 wrong address");
        // R3: clear bits 7 and 0 only.
        reg_wr = 1; reg_wdata = 8'h81; cycle("R3 partial clear");
        // R10: set beats clear on bit 1.
        reg_wr = 1; reg_wdata = 8'h02; pmon1_evt = 1; cycle("R10 set wins");
        // R7: clear strobe with same-cycle error -> first error.
        reg_wr = 1; reg_wdata = 8'h28; cycle("R3 clear error flags");
        first_clr = 1; bus_err = 2'b10; cycle("R7 clear plus error");
        first_clr = 1; cycle("R7 clear only");
        bus_err = 2'b01; cycle("R5 first after clear");
        // R8: reserved bits written.
        reg_wr = 1; reg_wdata = 8'h14; cycle("R8 reserved write");
        // R9: secondary side hides and ignores bit 6.
        secondary_side = 1; businit_evt = 1; cycle("R9 secondary");
        reg_wr = 1; reg_wdata = 8'hFF; businit_evt = 1; cycle("R9 secondary clear");
        secondary_side = 0; cycle("R9 primary again");
        // R1: cold reset clears everything.
        irq_evt = 1; cycle("R4 irq");
        pwrgood_n = 0; cycle("R1 cold reset");
        pwrgood_n = 1;

        // Random traffic.
        for (int i = 0; i < 4000; i++) begin
            irq_evt     = ($urandom % 8) == 0;
            businit_evt = ($urandom % 8) == 0;
            pmon0_evt   = ($urandom % 6) == 0;
            pmon1_evt   = ($urandom % 6) == 0;
            bus_err     = (($urandom % 4) == 0) ? 2'($urandom) : 2'b00;
            first_clr   = ($urandom % 10) == 0;
            reg_wr      = ($urandom % 3) == 0;
            reg_wdata   = 8'($urandom);
            reg_addr    = (($urandom % 5) == 0) ? 8'($urandom) : OFS;
            warm_rst_n  = ($urandom % 7) != 0;
            secondary_side = ($urandom % 50) == 0 ? ~secondary_side : secondary_side;
            pwrgood_n   = ($urandom % 300) != 0;
            cycle("R3 R5 R6 R7 random");
            pwrgood_n = 1; warm_rst_n = 1;
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule